// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block works out the order of column addresses inside one read or write burst of a double-data-rate SDRAM controller. A start pulse brings in the starting column, a burst-length code and an ordering flag. These three values normally come from the controller's copy of the memory's mode settings. Data moves on both clock edges, so the block delivers two beat addresses in every clock cycle, one for the even beat and one for the odd beat. It raises a valid flag while a burst runs and a last flag on the final pair.

Two orderings are supported, and the choice is made per burst. Sequential ordering counts upward from the start column and wraps inside the aligned window of the burst length. Interleaved ordering XORs the start column with the beat index. A new start may arrive in any cycle. It cuts off the running burst, so column commands can follow each other with no idle cycle.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, beat_vld and last_pair are 0 and both column outputs are 0.
- R2: A start sampled with a valid length code makes beat_vld high from the next cycle for BL/2 consecutive cycles. last_pair is high only in the final one of those cycles. If no new start arrives, beat_vld is low in the cycle after that.
- R3: The length code bl_sel selects the burst length: 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats.
- R4: When burst_il is 0 (sequential), beat i has low log2(BL) bits equal to (start + i) mod BL. The bits above them equal those of the start column.
- R5: When burst_il is 1 (interleaved), beat i has low log2(BL) bits equal to start XOR i. The bits above them equal those of the start column.
- R6: In pair cycle k, col_even carries beat 2k and col_odd carries beat 2k+1.
- R7: A valid start that arrives during a burst abandons that burst. The next cycle shows pair 0 of the new burst.
- R8: A valid start in the cycle of the last pair gives the new burst's first pair in the very next cycle, with no gap in beat_vld.
- R9: A start with bl_sel = 2'b00 is ignored: an idle block stays idle and a running burst continues unchanged.
- R10: While beat_vld is low, col_even, col_odd and last_pair are all 0.
- R11: Column, length and ordering are captured at the start. Later changes on those inputs do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the values on the other inputs |
| start_col | input | COL_W | Starting column address |
| bl_sel | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 reserved) |
| burst_il | input | 1 | Ordering: 0 sequential, 1 interleaved |
| beat_vld | output | 1 | A beat pair is being presented |
| col_even | output | COL_W | Column address of the even beat of the pair |
| col_odd | output | COL_W | Column address of the odd beat of the pair |
| last_pair | output | 1 | The current pair closes the burst |

## Verification
The assertions assume that start and bl_sel are known (not X) at every rising edge after reset, and that any change on the captured inputs happens between edges. The bench changes every input on the falling edge, so each value is stable across the edge that samples it. It covers the reserved length code both while idle and during a burst. After each start it scrambles the column, length and ordering inputs so that R11 is exercised, and it never leaves start unknown.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Beat index width inside the largest (8-beat) burst
    localparam int unsigned OFS_W  = 3;
    // Pair index width: two beats per clock
    localparam int unsigned PAIR_W = OFS_W - 1;

    typedef enum logic [1:0] {
        BL_RSVD  = 2'b00,
        BL_TWO   = 2'b01,
        BL_FOUR  = 2'b10,
        BL_EIGHT = 2'b11
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import colgen_pkg::*;
(
    input  bl_code_e           code,
    output logic               code_ok,
    output logic [OFS_W-1:0]   beat_mask,
    output logic [PAIR_W-1:0]  final_pair
);

    always_comb begin
        code_ok    = 1'b1;
        beat_mask  = '0;
        final_pair = '0;
        case (code)
            BL_TWO: begin
                beat_mask  = 3'b001;
                final_pair = 2'd0;
            end
            BL_FOUR: begin
                beat_mask  = 3'b011;
                final_pair = 2'd1;
            end
            BL_EIGHT: begin
                beat_mask  = 3'b111;
                final_pair = 2'd3;
            end
            default: code_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_lane.sv
module burst_lane
    import colgen_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [OFS_W-1:0] mask,
    input  logic [OFS_W-1:0] beat,
    input  order_e           order,
    output logic [COL_W-1:0] addr
);

    logic [OFS_W-1:0] low;
    logic [OFS_W-1:0] moved;

    always_comb begin
        low = base[OFS_W-1:0];
        if (order == ORD_XOR) begin
            moved = low ^ beat;
        end else begin
            moved = low + beat;
        end
        addr              = base;
        addr[OFS_W-1:0]   = (low & ~mask) | (moved & mask);
    end

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
    import colgen_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       bl_sel,
    input  logic             burst_il,
    output logic             beat_vld,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             last_pair
);

    localparam int unsigned LANES = 2;

    typedef struct packed {
        logic              active;
        logic [COL_W-1:0]  base;
        logic [OFS_W-1:0]  mask;
        logic [PAIR_W-1:0] last_idx;
        logic [PAIR_W-1:0] pair;
        order_e            order;
    } state_t;

    state_t st_d, st_q;

    logic              dec_ok;
    logic [OFS_W-1:0]  dec_mask;
    logic [PAIR_W-1:0] dec_last;
    logic              is_last;
    logic [COL_W-1:0]  lane_addr [LANES];

    burst_len_decode u_dec (
        .code       (bl_code_e'(bl_sel)),
        .code_ok    (dec_ok),
        .beat_mask  (dec_mask),
        .final_pair (dec_last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OFS_W-1:0] beat_idx;
        assign beat_idx = {st_q.pair, 1'(g)};
        burst_lane #(.COL_W(COL_W)) u_lane (
            .base  (st_q.base),
            .mask  (st_q.mask),
            .beat  (beat_idx),
            .order (st_q.order),
            .addr  (lane_addr[g])
        );
    end

    assign is_last = st_q.active && (st_q.pair == st_q.last_idx);

    always_comb begin
        st_d = st_q;
        if (start && dec_ok) begin
            st_d.active   = 1'b1;
            st_d.base     = start_col;
            st_d.mask     = dec_mask;
            st_d.last_idx = dec_last;
            st_d.pair     = '0;
            st_d.order    = order_e'(burst_il);
        end else if (st_q.active) begin
            if (is_last) begin
                st_d.active = 1'b0;
                st_d.pair   = '0;
            end else begin
                st_d.pair   = st_q.pair + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld  = st_q.active;
    assign last_pair = is_last;
    assign col_even  = st_q.active ? lane_addr[0] : '0;
    assign col_odd   = st_q.active ? lane_addr[1] : '0;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int unsigned COL_W = 10,
    parameter int unsigned OFS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       bl_sel,
    input logic             beat_vld,
    input logic [COL_W-1:0] col_even,
    input logic [COL_W-1:0] col_odd,
    input logic             last_pair
);

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bl_sel != 2'b00) |=> beat_vld);

    // R2
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_pair |-> beat_vld);

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pair && !(start && bl_sel != 2'b00)) |=> !beat_vld);

    // R2
    burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !last_pair) |=> beat_vld);

    // R9
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld && !(start && bl_sel != 2'b00)) |=> !beat_vld);

    // R4
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |-> (col_even[COL_W-1:OFS_W] == col_odd[COL_W-1:OFS_W]));

    // R6
    pair_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |-> (col_even[0] != col_odd[0]));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld |-> (col_even == '0 && col_odd == '0 && !last_pair));

endmodule

bind ddr_burst_colgen colgen_chk #(.COL_W(COL_W), .OFS_W(colgen_pkg::OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bl_sel    (bl_sel),
    .beat_vld  (beat_vld),
    .col_even  (col_even),
    .col_odd   (col_odd),
    .last_pair (last_pair)
);

// File: tb/sim_ddr_burst_colgen.sv
`timescale 1ns/1ps
module sim_ddr_burst_colgen;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [1:0]       bl_sel = 2'b00;
    logic             burst_il = 1'b0;
    logic             beat_vld;
    logic [COL_W-1:0] col_even;
    logic [COL_W-1:0] col_odd;
    logic             last_pair;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ddr_burst_colgen #(.COL_W(COL_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .bl_sel    (bl_sel),
        .burst_il  (burst_il),
        .beat_vld  (beat_vld),
        .col_even  (col_even),
        .col_odd   (col_odd),
        .last_pair (last_pair)
    );

    typedef struct packed {
        logic [9:0] col;
        logic [1:0] bl;
        logic       il;
        logic [9:0] last_odd;
    } vec_t;

    // start column, length code, ordering, expected address of the final beat
    localparam vec_t VECS [10] = '{
        '{10'h3F5, 2'd3, 1'b0, 10'h3F4},
        '{10'h3F5, 2'd3, 1'b1, 10'h3F2},
        '{10'h12B, 2'd2, 1'b0, 10'h12A},
        '{10'h12B, 2'd2, 1'b1, 10'h128},
        '{10'h001, 2'd1, 1'b0, 10'h000},
        '{10'h001, 2'd1, 1'b1, 10'h000},
        '{10'h200, 2'd3, 1'b0, 10'h207},
        '{10'h200, 2'd3, 1'b1, 10'h207},
        '{10'h0FE, 2'd2, 1'b0, 10'h0FD},
        '{10'h0FE, 2'd2, 1'b1, 10'h0FD}
    };

    function automatic int exp_addr(input int col, input int bl, input int il, input int beat);
        int m;
        int lo;
        m = (1 << bl) - 1;
        if (il != 0) lo = (col & m) ^ beat;
        else         lo = ((col & m) + beat) & m;
        return (col & ~m & 10'h3FF) | lo;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int np;
        int e0;
        int e1;
        np = (1 << v.bl) / 2;
        @(negedge clk);
        start = 1'b1; start_col = v.col; bl_sel = v.bl; burst_il = v.il;
        @(negedge clk);
        // R11: scramble the captured inputs while the burst runs
        start = 1'b0; start_col = ~v.col; bl_sel = ~v.bl; burst_il = ~v.il;
        for (int k = 0; k < np; k++) begin
            e0 = exp_addr(v.col, v.bl, v.il, 2 * k);
            e1 = exp_addr(v.col, v.bl, v.il, 2 * k + 1);
            chk(beat_vld == 1'b1, "R2 valid", beat_vld, 1);
            chk(col_even == e0, v.il ? "R5/R6/R11 even" : "R4/R6/R11 even", col_even, e0);
            chk(col_odd == e1, v.il ? "R5/R6/R11 odd" : "R4/R6/R11 odd", col_odd, e1);
            chk(last_pair == (k == np - 1), "R2 last", last_pair, k == np - 1);
            if (k == np - 1) chk(col_odd == v.last_odd, "R3 final beat", col_odd, v.last_odd);
            if (k < np - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(beat_vld == 1'b0, "R2 end", beat_vld, 0);
        chk(col_even == 0 && col_odd == 0, "R10 quiet", col_even, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(beat_vld == 0 && last_pair == 0, "R1 reset flags", beat_vld, 0);
        chk(col_even == 0 && col_odd == 0, "R1 reset cols", col_even, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld == 0, "R1 after reset", beat_vld, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R7: restart in the middle of an 8-beat burst
        @(negedge clk);
        start = 1'b1; start_col = 10'h010; bl_sel = 2'd3; burst_il = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(col_even == 10'h010, "R7 first burst pair0", col_even, 10'h010);
        @(negedge clk);
        chk(col_even == 10'h012 && last_pair == 0, "R7 first burst pair1", col_even, 10'h012);
        start = 1'b1; start_col = 10'h033; bl_sel = 2'd2; burst_il = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(col_even == 10'h033, "R7 restart even", col_even, 10'h033);
        chk(col_odd == 10'h032, "R7 restart odd", col_odd, 10'h032);
        chk(last_pair == 0, "R7 restart last", last_pair, 0);
        @(negedge clk);
        chk(col_even == 10'h031 && col_odd == 10'h030, "R7 second pair", col_even, 10'h031);
        chk(last_pair == 1, "R7 last", last_pair, 1);
        @(negedge clk);
        chk(beat_vld == 0, "R7 end", beat_vld, 0);

        // R8: back-to-back 2-beat bursts
        @(negedge clk);
        start = 1'b1; start_col = 10'h100; bl_sel = 2'd1; burst_il = 1'b0;
        @(negedge clk);
        start_col = 10'h205;
        chk(col_even == 10'h100 && col_odd == 10'h101, "R8 first", col_even, 10'h100);
        chk(last_pair == 1, "R8 first last", last_pair, 1);
        @(negedge clk);
        start = 1'b0;
        chk(beat_vld == 1, "R8 no gap", beat_vld, 1);
        chk(col_even == 10'h205 && col_odd == 10'h204, "R8 second", col_odd, 10'h204);
        @(negedge clk);
        chk(beat_vld == 0, "R8 end", beat_vld, 0);

        // R9: reserved code while idle
        @(negedge clk);
        start = 1'b1; start_col = 10'h3FF; bl_sel = 2'd0;
        @(negedge clk);
        start = 1'b0;
        chk(beat_vld == 0, "R9 idle ignored", beat_vld, 0);
        chk(col_even == 0 && col_odd == 0, "R9/R10 idle cols", col_even, 0);

        // R9: reserved code during a burst
        start = 1'b1; start_col = 10'h040; bl_sel = 2'd2; burst_il = 1'b0;
        @(negedge clk);
        start = 1'b1; start_col = 10'h3FF; bl_sel = 2'd0;
        chk(col_even == 10'h040 && col_odd == 10'h041, "R9 pair0", col_even, 10'h040);
        @(negedge clk);
        start = 1'b0;
        chk(col_even == 10'h042 && col_odd == 10'h043, "R9 burst continues", col_even, 10'h042);
        chk(last_pair == 1, "R9 last", last_pair, 1);
        @(negedge clk);
        chk(beat_vld == 0, "R9 end", beat_vld, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule